// File: doc/BRIEF.md
# Paired-sample hit count aggregation stage

This block is one summing stage in a tree of readout stages for a 128×128 detector array. Lower stages deliver, for every region they cover, a small hit count for each 2.5 ns sample. This stage adds the counts of all its input regions into one count for the larger area it covers, and passes that count up to the next stage.

The block runs from a single 200 MHz clock. It takes two samples in each cycle, one "even" and one "odd", which together stand for the two 2.5 ns samples of that 5 ns period. Each sample goes through its own adder tree lane. The lane result is cut to a fixed output width that is chosen from the expected event rate. A sum that does not fit is clamped, and the lane overflow flag is set.

Each input region also brings its own overflow flag. This lets a region built as an adder tree and a region built as a pulse counter both report a lost count. The flags of one sample are ORed together and travel with that sample's sum. The even result always appears on the even output and the odd result on the odd output, so the order of the samples is kept.

Top module: `hit_pair_accum`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are all zero: `out_valid`, both sums and both overflow flags.
- R2: A sample pair taken with `in_valid` high at clock edge k appears at the outputs after edge k+1. At that point `out_valid` is high.
- R3: The even lane sum is the unsigned sum of all N region counts in `cnt_even`. Region i sits at bits [i*W +: W].
- R4: The odd lane sum is computed in the same way from `cnt_odd`, independently of the even lane. Each lane's result stays on its own output, so the two samples of a pair are never swapped.
- R5: When a lane total exceeds 2^SUM_W−1 (255 by default), that lane outputs 2^SUM_W−1 and raises its overflow flag. A total of exactly 2^SUM_W−1 is passed through unchanged with the flag low.
- R6: If any bit of a lane's region flag input (`flag_even` or `flag_odd`) is set in a valid pair, that lane's overflow output is high for that pair. The sum is still reported as in R3, R4 and R5.
- R7: A pair taken with `in_valid` low is ignored. Two edges later `out_valid` is low and both sums and both flags read zero, whatever counts and flags were applied.
- R8: A new pair is accepted on every cycle. Back-to-back valid pairs each come out on consecutive cycles, with nothing lost and nothing merged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 200 MHz stage clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the current pair of samples as valid |
| cnt_even | input | N*W | Region counts of the even sample, region i at [i*W +: W] |
| cnt_odd | input | N*W | Region counts of the odd sample, same packing |
| flag_even | input | N | Per-region overflow flags for the even sample |
| flag_odd | input | N | Per-region overflow flags for the odd sample |
| out_valid | output | 1 | The summed pair at the outputs is valid |
| sum_even | output | SUM_W | Clamped total of the even sample |
| ovf_even | output | 1 | Even sample lost counts: a region flag was set or the total was clamped |
| sum_odd | output | SUM_W | Clamped total of the odd sample |
| ovf_odd | output | 1 | Odd sample lost counts |

## Verification
The hardest case to reach from the ports is a lane total that sits exactly on the clamp limit, or one count above it. With random sparse or dense traffic these values are almost never hit. The stimulus therefore sweeps the number of fully loaded regions from zero to N on the even lane and the complementary number on the odd lane. It then adds crafted pairs whose totals are exactly 255 and 256. A per-region sweep with different patterns on the two lanes makes any swap of lanes or any dropped region visible in the outputs.

// File: rtl/hit_accum_pkg.sv
package hit_accum_pkg;

  // Width that holds the full, unclamped total of the given regions.
  function automatic int tree_width(input int regions, input int cnt_w);
    return cnt_w + ((regions > 1) ? $clog2(regions) : 1);
  endfunction

  typedef enum logic {LANE_EVEN = 1'b0, LANE_ODD = 1'b1} lane_e;

endpackage

// File: rtl/hit_add_tree.sv
module hit_add_tree
  import hit_accum_pkg::*;
#(
  parameter int N = 64,
  parameter int W = 3,
  localparam int FULL_W = tree_width(N, W),
  localparam int LEVELS = (N > 1) ? $clog2(N) : 0,
  localparam int P = 1 << LEVELS
) (
  input  logic [N*W-1:0]    cnt,
  output logic [FULL_W-1:0] total
);

  for (genvar lvl = 0; lvl <= LEVELS; lvl++) begin : lv
    localparam int CNT = P >> lvl;
    logic [FULL_W-1:0] s [CNT];
    if (lvl == 0) begin : g_leaf
      for (genvar i = 0; i < CNT; i++) begin : g_in
        if (i < N) begin : g_real
          assign s[i] = FULL_W'(cnt[i*W +: W]);
        end else begin : g_pad
          assign s[i] = '0;
        end
      end
    end else begin : g_node
      for (genvar i = 0; i < CNT; i++) begin : g_add
        assign s[i] = lv[lvl-1].s[2*i] + lv[lvl-1].s[2*i+1];
      end
    end
  end

  assign total = lv[LEVELS].s[0];

endmodule

// File: rtl/hit_lane_sum.sv
module hit_lane_sum
  import hit_accum_pkg::*;
#(
  parameter int N = 64,
  parameter int W = 3,
  parameter int SUM_W = 8,
  localparam int FULL_W = tree_width(N, W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_in,
  input  logic             vld_s1,
  input  logic [N*W-1:0]   cnt,
  input  logic [N-1:0]     flags,
  output logic [SUM_W-1:0] sum,
  output logic             ovf
);

  localparam logic [FULL_W-1:0] LIM = FULL_W'((64'd1 << SUM_W) - 64'd1);

  logic [FULL_W-1:0] tree_total;
  logic [FULL_W-1:0] full_q;
  logic              flag_q;

  hit_add_tree #(.N(N), .W(W)) u_tree (
    .cnt   (cnt),
    .total (tree_total)
  );

  // Stage 1: register the full total and the merged region flags.
  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= '0;
      flag_q <= 1'b0;
    end else if (vld_in) begin
      full_q <= tree_total;
      flag_q <= |flags;
    end else begin
      full_q <= '0;
      flag_q <= 1'b0;
    end
  end

  // Stage 2: clamp to the rate-chosen width.
  always_ff @(posedge clk) begin
    if (rst || !vld_s1) begin
      sum <= '0;
      ovf <= 1'b0;
    end else if (full_q > LIM) begin
      sum <= SUM_W'(LIM);
      ovf <= 1'b1;
    end else begin
      sum <= full_q[SUM_W-1:0];
      ovf <= flag_q;
    end
  end

endmodule

// File: rtl/hit_pair_accum.sv
module hit_pair_accum
  import hit_accum_pkg::*;
#(
  parameter int N = 64,
  parameter int W = 3,
  parameter int SUM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [N*W-1:0]   cnt_even,
  input  logic [N*W-1:0]   cnt_odd,
  input  logic [N-1:0]     flag_even,
  input  logic [N-1:0]     flag_odd,
  output logic             out_valid,
  output logic [SUM_W-1:0] sum_even,
  output logic             ovf_even,
  output logic [SUM_W-1:0] sum_odd,
  output logic             ovf_odd
);

  logic             v_s1;
  logic [N*W-1:0]   cnt_l  [2];
  logic [N-1:0]     flag_l [2];
  logic [SUM_W-1:0] sum_l  [2];
  logic             ovf_l  [2];

  assign cnt_l[LANE_EVEN]  = cnt_even;
  assign cnt_l[LANE_ODD]   = cnt_odd;
  assign flag_l[LANE_EVEN] = flag_even;
  assign flag_l[LANE_ODD]  = flag_odd;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_s1      <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v_s1      <= in_valid;
      out_valid <= v_s1;
    end
  end

  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    hit_lane_sum #(.N(N), .W(W), .SUM_W(SUM_W)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .vld_in (in_valid),
      .vld_s1 (v_s1),
      .cnt    (cnt_l[ln]),
      .flags  (flag_l[ln]),
      .sum    (sum_l[ln]),
      .ovf    (ovf_l[ln])
    );
  end

  assign sum_even = sum_l[LANE_EVEN];
  assign ovf_even = ovf_l[LANE_EVEN];
  assign sum_odd  = sum_l[LANE_ODD];
  assign ovf_odd  = ovf_l[LANE_ODD];

endmodule

// File: rtl/hit_pair_accum_chk.sv
module hit_pair_accum_chk #(
  parameter int N = 64,
  parameter int W = 3,
  parameter int SUM_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [N*W-1:0]   cnt_even,
  input logic [N*W-1:0]   cnt_odd,
  input logic [N-1:0]     flag_even,
  input logic [N-1:0]     flag_odd,
  input logic             out_valid,
  input logic [SUM_W-1:0] sum_even,
  input logic             ovf_even,
  input logic [SUM_W-1:0] sum_odd,
  input logic             ovf_odd
);

  // Counts edges since reset, so that no $past reaches into reset.
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && sum_even == '0 && sum_odd == '0 && !ovf_even && !ovf_odd));

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  assert_zero_even_R3: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && $past(in_valid, 2) && $past(cnt_even, 2) == '0 && $past(flag_even, 2) == '0)
    |-> (sum_even == '0 && !ovf_even));

  assert_zero_odd_R4: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && $past(in_valid, 2) && $past(cnt_odd, 2) == '0 && $past(flag_odd, 2) == '0)
    |-> (sum_odd == '0 && !ovf_odd));

  assert_flag_even_R6: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && $past(in_valid, 2) && ($past(flag_even, 2) != '0)) |-> ovf_even);

  assert_flag_odd_R6: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && $past(in_valid, 2) && ($past(flag_odd, 2) != '0)) |-> ovf_odd);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (sum_even == '0 && sum_odd == '0 && !ovf_even && !ovf_odd));

endmodule

bind hit_pair_accum hit_pair_accum_chk #(.N(N), .W(W), .SUM_W(SUM_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .cnt_even  (cnt_even),
  .cnt_odd   (cnt_odd),
  .flag_even (flag_even),
  .flag_odd  (flag_odd),
  .out_valid (out_valid),
  .sum_even  (sum_even),
  .ovf_even  (ovf_even),
  .sum_odd   (sum_odd),
  .ovf_odd   (ovf_odd)
);

// File: tb/hit_pair_accum_bench.sv
module hit_pair_accum_bench;
  localparam int N = 64;
  localparam int W = 3;
  localparam int SUM_W = 8;
  localparam int MAX = (1 << SUM_W) - 1;
  localparam int CMAX = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic             in_valid;
  logic [N*W-1:0]   cnt_even, cnt_odd;
  logic [N-1:0]     flag_even, flag_odd;
  logic             out_valid;
  logic [SUM_W-1:0] sum_even, sum_odd;
  logic             ovf_even, ovf_odd;

  hit_pair_accum #(.N(N), .W(W), .SUM_W(SUM_W)) u_hit_pair_accum (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .cnt_even(cnt_even), .cnt_odd(cnt_odd),
    .flag_even(flag_even), .flag_odd(flag_odd),
    .out_valid(out_valid), .sum_even(sum_even), .ovf_even(ovf_even),
    .sum_odd(sum_odd), .ovf_odd(ovf_odd)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Expectations for the pair applied before the previous edge.
  int    pe_s = 0, po_s = 0;
  int    pv = 0, pe_o = 0, po_o = 0, ppv = 0;
  string pe_t = "R1", po_t = "R1", pv_t = "R1";

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic lane_model(input logic v, input logic [N*W-1:0] c, input logic [N-1:0] f,
                            input bit odd, output int s, output int o, output string t);
    int full = 0;
    for (int i = 0; i < N; i++) full += int'(c[i*W +: W]);
    if (!v) begin
      s = 0; o = 0; t = "R7";
    end else begin
      s = (full > MAX) ? MAX : full;
      o = ((f != '0) || full > MAX) ? 1 : 0;
      if (f != '0)       t = "R6";
      else if (full > MAX) t = "R5";
      else               t = odd ? "R4" : "R3";
    end
  endtask

  task automatic step();
    int es, os, eo, oo;
    string et, ot;
    lane_model(in_valid, cnt_even, flag_even, 1'b0, es, eo, et);
    lane_model(in_valid, cnt_odd, flag_odd, 1'b1, os, oo, ot);
    @(posedge clk);
    #1;
    chk(pv_t, "out_valid", int'(out_valid), pv);
    chk(pe_t, "sum_even", int'(sum_even), pe_s);
    chk(pe_t, "ovf_even", int'(ovf_even), pe_o);
    chk(po_t, "sum_odd", int'(sum_odd), po_s);
    chk(po_t, "ovf_odd", int'(ovf_odd), po_o);
    ppv = pv;
    pv = int'(in_valid);
    pv_t = in_valid ? ((ppv != 0) ? "R8" : "R2") : "R7";
    pe_s = es; pe_o = eo; pe_t = et;
    po_s = os; po_o = oo; po_t = ot;
  endtask

  task automatic fill_full(output logic [N*W-1:0] c, input int k);
    c = '0;
    for (int i = 0; i < N; i++) if (i < k) c[i*W +: W] = W'(CMAX);
  endtask

  task automatic fill_rand(output logic [N*W-1:0] c, input int pct);
    c = '0;
    for (int i = 0; i < N; i++)
      if (($urandom % 100) < pct) c[i*W +: W] = W'(1 + ($urandom % CMAX));
  endtask

  initial begin
    // R1: reset with busy inputs must leave the outputs clear.
    in_valid = 1'b1;
    fill_rand(cnt_even, 90); fill_rand(cnt_odd, 90);
    flag_even = '1; flag_odd = '1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "out_valid", int'(out_valid), 0);
    chk("R1", "sum_even", int'(sum_even), 0);
    chk("R1", "sum_odd", int'(sum_odd), 0);
    chk("R1", "ovf_even", int'(ovf_even), 0);
    chk("R1", "ovf_odd", int'(ovf_odd), 0);
    rst = 1'b0;
    in_valid = 1'b0;
    flag_even = '0; flag_odd = '0;
    // R7: garbage while idle must not appear.
    step();
    cnt_even = '0; cnt_odd = '0;
    step();
    // R3 R4: all-zero pair, then per-region sweep with distinct lanes.
    in_valid = 1'b1;
    step();
    for (int i = 0; i < N; i++) begin
      for (int v = 1; v <= CMAX; v++) begin
        cnt_even = '0; cnt_odd = '0;
        cnt_even[i*W +: W] = W'(v);
        cnt_odd[(N-1-i)*W +: W] = W'(CMAX + 1 - v);
        step();
      end
    end
    // R5: sweep of fully loaded regions across the clamp limit.
    for (int k = 0; k <= N; k++) begin
      fill_full(cnt_even, k);
      fill_full(cnt_odd, N - k);
      step();
    end
    // R5: exact boundary totals 255 and 256.
    fill_full(cnt_even, 36); cnt_even[36*W +: W] = W'(3);
    fill_full(cnt_odd, 36);  cnt_odd[36*W +: W]  = W'(4);
    step();
    cnt_even[36*W +: W] = W'(4);
    cnt_odd[36*W +: W]  = W'(3);
    step();
    // R6: a single region flag on each lane with a small sum.
    cnt_even = '0; cnt_odd = '0;
    cnt_even[0 +: W] = W'(2);
    flag_even = '0; flag_even[N-1] = 1'b1;
    step();
    flag_even = '0; flag_odd = '0; flag_odd[5] = 1'b1;
    step();
    flag_odd = '0;
    // R8 R7: random sparse and dense streams, gaps and flags.
    for (int n = 0; n < 600; n++) begin
      in_valid = (($urandom % 100) < 80);
      fill_rand(cnt_even, (n < 300) ? 6 : 85);
      fill_rand(cnt_odd, (n < 300) ? 6 : 85);
      flag_even = '0; flag_odd = '0;
      if (($urandom % 100) < 10) flag_even[$urandom % N] = 1'b1;
      if (($urandom % 100) < 10) flag_odd[$urandom % N] = 1'b1;
      step();
    end
    in_valid = 1'b0;
    step();
    step();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule